// File: doc/BRIEF.md
# Register-mapped byte SPI master

This block is a byte-wide SPI master that sits behind a plain 32-bit register bus. Software chooses a serial clock rate and drives chip select through a configuration word. Writing a byte to the transmit word starts one 8-bit full-duplex exchange in mode 0, most significant bit first. When the exchange is over, the byte shifted in from the slave can be read from the receive word.

A fourth word drives side-band pins for the surrounding board logic. One bit hands ownership of the SPI lines to this master, and one bit requests a reconfiguration. Both are stored active-high and appear inverted on active-low pins. A three-bit field picks one of eight image slots.

The bus is a single-cycle write strobe with a byte address, and read data is combinational from the address. The two low address bits are ignored.

Top module: `spi_regbus_master`

## Requirements
- R1: After reset every register word reads zero, `spi_cs`, `spi_sck` and `slot_sel` are 0, and `own_n` and `reconf_n` are 1.
- R2: Word offsets decode as 0x00 config, 0x04 transmit, 0x08 receive, 0x0C control. Offsets 0x10 to 0x3C read zero and writes to them change nothing.
- R3: Config bits [3:0] hold a divide select S. Each SCK half period lasts 2^S bus clocks, so one exchange keeps busy for 16·2^S cycles.
- R4: Config bit 31 drives `spi_cs` directly. The pin changes only on a config write and stays put through an exchange.
- R5: A transmit write while idle shifts bits [7:0] out on `spi_mosi`, MSB first, as eight SCK pulses. MOSI changes only while SCK is low.
- R6: MISO is sampled on each rising SCK edge, MSB first. The received byte reads back in bits [7:0] of offset 0x08 and the upper bits read zero.
- R7: Config bit 8 is a read-only busy flag. It is set on the cycle after the starting write and cleared after the eighth falling SCK edge. SCK is low whenever the block is not busy.
- R8: A transmit write while busy is ignored: the running exchange neither restarts nor changes data or length.
- R9: Control bit 0 (ownership) and bit 1 (reconfiguration request) are held active-high and drive `own_n` and `reconf_n` inverted.
- R10: Control bits [10:8] drive `slot_sel` directly and read back in place.
- R11: Transmit bits [31:8] are ignored. Offset 0x04 reads back only the last byte written, in bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs | output | 1 | Chip select, software driven |
| own_n | output | 1 | Active-low SPI ownership enable |
| reconf_n | output | 1 | Active-low reconfiguration request |
| slot_sel | output | 3 | Image slot select |

## Verification
Exchanges run at divide selects 0 through 3, and a slave model captures MOSI and drives MISO. The byte pairs cover alternating bits, all ones against all zeros, and a pattern whose end bits differ from its middle bits. Together they separate bit-order faults, stuck lines and off-by-one shift errors. The measured rise-to-rise spacing and busy length separate the rate selections from each other. A second transmit write injected mid-exchange, and a transmit word with its upper bits set, show whether the length and data stay fixed. These checks and the reset read-back cover the remaining corner cases.

// File: rtl/spi_regbus_master.sv
module spi_regbus_master #(
  parameter int SEL_W  = 4,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs,
  output logic              own_n,
  output logic              reconf_n,
  output logic [2:0]        slot_sel
);
  localparam int CNT_W  = 1 << SEL_W;
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              wr_cfg, wr_tx, wr_ctl, start, tick;
  logic [SEL_W-1:0]  div_sel;
  logic              cs_q, en_q, req_q, busy, sck_q;
  logic [2:0]        slot_q;
  logic [7:0]        tx_q, rx_q, sh_q, rx_sh;
  logic [3:0]        bit_cnt;
  logic [CNT_W-1:0]  cnt, lo_mask;
  logic              unused_bits;

  assign word    = bus_addr[ADDR_W-1:2];
  assign wr_cfg  = bus_we && (word == WORD_W'(0));
  assign wr_tx   = bus_we && (word == WORD_W'(1));
  assign wr_ctl  = bus_we && (word == WORD_W'(3));
  assign start   = wr_tx && !busy;
  assign lo_mask = (CNT_W'(1) << div_sel) - CNT_W'(1);
  assign tick    = busy && ((cnt & lo_mask) == lo_mask);

  assign spi_sck  = sck_q;
  assign spi_mosi = sh_q[7];
  assign spi_cs   = cs_q;
  assign own_n    = ~en_q;
  assign reconf_n = ~req_q;
  assign slot_sel = slot_q;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[30:11]};

  always_comb begin
    bus_rdata = '0;
    case (word)
      WORD_W'(0): begin
        bus_rdata[31]          = cs_q;
        bus_rdata[8]           = busy;
        bus_rdata[SEL_W-1:0]   = div_sel;
      end
      WORD_W'(1): bus_rdata[7:0] = tx_q;
      WORD_W'(2): bus_rdata[7:0] = rx_q;
      WORD_W'(3): begin
        bus_rdata[0]    = en_q;
        bus_rdata[1]    = req_q;
        bus_rdata[10:8] = slot_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_sel <= '0;
      cs_q    <= 1'b0;
      en_q    <= 1'b0;
      req_q   <= 1'b0;
      slot_q  <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      sh_q    <= '0;
      rx_sh   <= '0;
      busy    <= 1'b0;
      sck_q   <= 1'b0;
      bit_cnt <= '0;
      cnt     <= '0;
    end else begin
      if (wr_cfg) begin
        cs_q    <= bus_wdata[31];
        div_sel <= bus_wdata[SEL_W-1:0];
      end
      if (wr_ctl) begin
        en_q   <= bus_wdata[0];
        req_q  <= bus_wdata[1];
        slot_q <= bus_wdata[10:8];
      end
      if (start) begin
        tx_q    <= bus_wdata[7:0];
        sh_q    <= bus_wdata[7:0];
        busy    <= 1'b1;
        sck_q   <= 1'b0;
        cnt     <= '0;
        bit_cnt <= '0;
      end else if (busy) begin
        cnt <= cnt + CNT_W'(1);
        if (tick) begin
          if (!sck_q) begin
            sck_q   <= 1'b1;
            rx_sh   <= {rx_sh[6:0], spi_miso};
            bit_cnt <= bit_cnt + 4'd1;
          end else begin
            sck_q <= 1'b0;
            if (bit_cnt == 4'd8) begin
              busy    <= 1'b0;
              rx_q    <= rx_sh;
              bit_cnt <= '0;
            end else begin
              sh_q <= {sh_q[6:0], 1'b0};
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_regbus_master_chk.sv
module spi_regbus_master_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              spi_sck,
  input logic              spi_mosi,
  input logic              spi_cs,
  input logic              own_n,
  input logic              reconf_n,
  input logic [2:0]        slot_sel,
  input logic              busy,
  input logic [3:0]        bit_cnt
);
  logic w_cfg, w_tx, w_ctl, unused_chk;
  assign w_cfg = bus_we && (bus_addr[ADDR_W-1:2] == '0);
  assign w_tx  = bus_we && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));
  assign w_ctl = bus_we && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(3));
  assign unused_chk = ^{bus_addr[1:0], bus_wdata[31:11], bus_wdata[7:2]};

  AST_CS_ONLY_ON_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(w_cfg) |-> $stable(spi_cs)); // R4
  AST_MOSI_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> $stable(spi_mosi)); // R5
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (w_tx && !busy) |=> busy); // R7
  AST_SCK_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sck); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (w_tx && busy) |=> (!busy || bit_cnt >= $past(bit_cnt))); // R8
  AST_SIDEBAND_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(w_ctl) |-> (own_n == !$past(bus_wdata[0]) && reconf_n == !$past(bus_wdata[1]))); // R9
  AST_SLOT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(w_ctl) |-> (slot_sel == $past(bus_wdata[10:8]))); // R10
endmodule

bind spi_regbus_master spi_regbus_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
  .spi_cs(spi_cs), .own_n(own_n), .reconf_n(reconf_n),
  .slot_sel(slot_sel), .busy(busy), .bit_cnt(bit_cnt)
);

// File: tb/sim_spi_regbus_master.sv
module sim_spi_regbus_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_mosi, spi_cs, own_n, reconf_n;
  logic [2:0]  slot_sel;
  logic [7:0]  sl = '0;
  logic        spi_miso;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, rises = 0, rise1 = -1, rise2 = -1, hi_changes = 0;
  logic [7:0] cap = '0;
  logic prev_sck = 1'b0, prev_mosi = 1'b0;

  assign spi_miso = sl[7];
  always #4 clk = ~clk;

  spi_regbus_master u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs),
    .own_n(own_n), .reconf_n(reconf_n), .slot_sel(slot_sel)
  );

  // slave model and line monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (spi_sck && !prev_sck) begin
      rises <= rises + 1;
      cap   <= {cap[6:0], spi_mosi};
      if (rise1 < 0) rise1 <= cyc;
      else if (rise2 < 0) rise2 <= cyc;
    end
    if (!spi_sck && prev_sck) sl <= {sl[6:0], 1'b0};
    if (spi_sck && prev_sck && spi_mosi != prev_mosi) hi_changes <= hi_changes + 1;
    prev_sck  <= spi_sck;
    prev_mosi <= spi_mosi;
  end

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(logic [5:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic bus_rd(logic [5:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic run_xfer(int sel, logic [31:0] txw, logic [7:0] mi, bit bump);
    int n;
    logic [31:0] d;
    bus_wr(6'h00, 32'h8000_0000 | sel);
    sl = mi; rises = 0; rise1 = -1; rise2 = -1; cap = '0; hi_changes = 0;
    bus_wr(6'h04, txw);
    n = 0; bus_addr = '0; #1;
    while (bus_rdata[8] && n < 100000) begin
      if (bump && n == 5) begin bus_we = 1'b1; bus_addr = 6'h04; bus_wdata = 32'h99; end
      @(negedge clk);
      check("R4 cs held", {31'b0, spi_cs}, 32'd1);
      bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; #1;
      n++;
    end
    check("R3/R7/R8 busy length", n, 16 << sel);
    check("R3 sck period", rise2 - rise1, 2 << sel);
    check("R5/R8 rise count", rises, 8);
    check("R5/R8 mosi byte", {24'b0, cap}, {24'b0, txw[7:0]});
    check("R5 mosi steady high", hi_changes, 0);
    check("R7 sck idle", {31'b0, spi_sck}, 32'd0);
    bus_rd(6'h08, d);
    check("R6 rx byte", d, {24'b0, mi});
  endtask

  localparam logic [19:0] VEC [4] = '{
    {4'd0, 8'hA5, 8'h3C},
    {4'd1, 8'hFF, 8'h00},
    {4'd2, 8'h00, 8'hFF},
    {4'd3, 8'h81, 8'h7E}
  };

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      bus_rd(6'(a * 4), d);
      check("R1 reset read", d, 32'd0);
    end
    check("R1 pins", {26'b0, spi_cs, spi_sck, own_n, reconf_n, slot_sel}, 32'h0000_0018);

    // R2 / R3 / R4 config readback and cs pin
    bus_wr(6'h00, 32'h8000_0003);
    bus_rd(6'h00, d);
    check("R2/R3 cfg readback", d, 32'h8000_0003);
    check("R4 cs pin on", {31'b0, spi_cs}, 32'd1);
    bus_wr(6'h10, 32'hFFFF_FFFF);
    bus_wr(6'h3C, 32'hFFFF_FFFF);
    bus_rd(6'h10, d); check("R2 reserved 0x10", d, 32'd0);
    bus_rd(6'h3C, d); check("R2 reserved 0x3C", d, 32'd0);
    bus_rd(6'h00, d); check("R2 no alias", d, 32'h8000_0003);
    bus_wr(6'h00, 32'h0);
    check("R4 cs pin off", {31'b0, spi_cs}, 32'd0);

    // R9 / R10 side-band
    bus_wr(6'h0C, 32'h0000_0703);
    check("R9/R10 pins all", {27'b0, own_n, reconf_n, slot_sel}, 32'h0000_0007);
    bus_rd(6'h0C, d); check("R10 ctrl readback", d, 32'h0000_0703);
    bus_wr(6'h0C, 32'h0000_0501);
    check("R9/R10 pins partial", {27'b0, own_n, reconf_n, slot_sel}, 32'h0000_000D);
    bus_wr(6'h0C, 32'h0000_0002);
    check("R9/R10 pins req only", {27'b0, own_n, reconf_n, slot_sel}, 32'h0000_0010);

    // vector table: R3 R5 R6 R7
    for (int i = 0; i < 4; i++)
      run_xfer(int'(VEC[i][19:16]), {24'b0, VEC[i][15:8]}, VEC[i][7:0], 1'b0);

    // R11 upper transmit bits ignored
    run_xfer(0, 32'hFFFF_FF5A, 8'h96, 1'b0);
    bus_rd(6'h04, d); check("R11 tx readback", d, 32'h0000_005A);

    // R8 write while busy ignored
    run_xfer(1, 32'h0000_003C, 8'hC3, 1'b1);
    bus_rd(6'h04, d); check("R8 tx unchanged", d, 32'h0000_003C);

    // R1 reset mid-operation clears state
    bus_wr(6'h0C, 32'h0000_0603);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 pins after reset", {26'b0, spi_cs, spi_sck, own_n, reconf_n, slot_sel}, 32'h0000_0018);
    bus_rd(6'h08, d); check("R1 rx cleared", d, 32'd0);
    bus_rd(6'h00, d); check("R1 cfg cleared", d, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule